// File: doc/BRIEF.md
# Control Register Store Unit

This unit executes the group of 16-bit instructions that copy a control or system register into a general register, or push one onto a descending stack in memory. The six sources are the status register (SR), the global base register (GBR), the vector base register (VBR), the multiply-accumulate high and low halves (MACH, MACL) and the procedure return register (PR). The sources arrive as plain input values. The unit reads the addressed general register through a combinational read port. It returns its result through a one-cycle register write-back port and, for push forms, through a 32-bit memory write request that is held until memory signals ready.

An instruction is accepted on any clock edge where `instr_valid` is high and the unit is not busy. A register move finishes in one cycle. A push first writes the decremented pointer back to the general register and then issues the store to that decremented address. The SR push spends one extra cycle before its store request. When an instruction completes, the unit pulses `done` and reports on `cyc_count` how many cycles it took, counting memory wait cycles. An encoding outside the group raises `illegal` and has no other effect.

Top module: `crs_store_unit`

## Requirements
- R1: Encoding 0000nnnn ssss0010 with ssss=0001 (GBR) or ssss=0010 (VBR) writes the selected value to register n (bits 11:8) on `wb_en`/`wb_idx`/`wb_data` in the cycle after acceptance.
- R2: Encoding 0000nnnn ssss1010 with ssss=0000 (MACH), 0001 (MACL) or 0010 (PR) writes the selected value to register n in the cycle after acceptance.
- R3: A push (0100nnnn ssss0011 with ssss=0000 SR, 0001 GBR, 0010 VBR; or 0100nnnn ssss0010 with ssss=0000 MACH, 0001 MACL, 0010 PR) writes Rn-4 back to register n in the cycle after acceptance, wrapping modulo 2^32. The write-back happens no later than the store request.
- R4: A push raises `mem_req` with `mem_addr` = Rn-4 and `mem_wdata` = the selected value. While `mem_ready` is low, the request, address and data stay unchanged.
- R5: For the SR push, the write-back cycle carries no memory request. `mem_req` rises one cycle later than for the other pushes.
- R6: `done` pulses for one cycle when an instruction completes. `cyc_count` then holds 1 for a move and for a non-SR push without wait, 2 for an SR push without wait, plus one for each cycle that `mem_ready` was low during the request.
- R7: Any other encoding, including a valid pattern with an unlisted selector, pulses `illegal` in the cycle after acceptance. It produces no write-back, no memory request and no `done`.
- R8: `busy` is high from the cycle after a push is accepted until the cycle after its store handshake. `instr_valid` is ignored while `busy` is high.
- R9: During and right after reset, `wb_en`, `mem_req`, `busy`, `done` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| gpr_raddr | output | 4 | General register read index (instr bits 11:8) |
| gpr_rdata | input | 32 | Value of the addressed general register |
| sr_val | input | 32 | Status register value |
| gbr_val | input | 32 | Global base register value |
| vbr_val | input | 32 | Vector base register value |
| mach_val | input | 32 | Multiply-accumulate high value |
| macl_val | input | 32 | Multiply-accumulate low value |
| pr_val | input | 32 | Procedure return register value |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 4 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Store address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| busy | output | 1 | Push in flight, new instructions ignored |
| done | output | 1 | Instruction completed this cycle |
| cyc_count | output | 8 | Cycles used by the completed instruction |
| illegal | output | 1 | Unrecognised encoding accepted |

## Verification
A vector table runs every legal source selector in both the move form and the push form. Each entry uses a different destination register whose value is distinct, so a wrong source select or a wrong index shows up as a data mismatch. Pushes from pointers 2 and 0 show whether the decrement wraps. Pushes with 0, 2 and 3 wait cycles separate the fixed SR extra cycle from the cycles added by memory. Encodings with a wrong selector, a wrong low nibble or a wrong top nibble must set only the illegal flag. A directed test drives a move while a push is stalled and confirms that the move never reaches the write-back port.

// File: rtl/crs_pkg.sv
package crs_pkg;

    localparam int INSTR_W = 16;
    localparam int RIDX_W  = 4;

    typedef enum logic [2:0] {
        SRC_SR, SRC_GBR, SRC_VBR, SRC_MACH, SRC_MACL, SRC_PR
    } src_e;

    typedef struct packed {
        logic              ok;
        logic              push;
        src_e              src;
        logic [RIDX_W-1:0] rn;
    } dec_t;

    typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_STORE} st_e;

    // Group decode: top nibble picks move (0) or push (4), low nibble picks
    // the control or system register family, bits 7:4 pick the source.
    function automatic dec_t decode(input logic [INSTR_W-1:0] ins);
        dec_t d;
        logic [3:0] sel;
        d     = '0;
        d.rn  = ins[11:8];
        sel   = ins[7:4];
        if (ins[15:12] == 4'h0 && ins[3:0] == 4'h2) begin
            d.push = 1'b0;
            if (sel == 4'h1) begin d.ok = 1'b1; d.src = SRC_GBR; end
            if (sel == 4'h2) begin d.ok = 1'b1; d.src = SRC_VBR; end
        end else if (ins[15:12] == 4'h0 && ins[3:0] == 4'hA) begin
            d.push = 1'b0;
            if (sel == 4'h0) begin d.ok = 1'b1; d.src = SRC_MACH; end
            if (sel == 4'h1) begin d.ok = 1'b1; d.src = SRC_MACL; end
            if (sel == 4'h2) begin d.ok = 1'b1; d.src = SRC_PR;   end
        end else if (ins[15:12] == 4'h4 && ins[3:0] == 4'h3) begin
            d.push = 1'b1;
            if (sel == 4'h0) begin d.ok = 1'b1; d.src = SRC_SR;  end
            if (sel == 4'h1) begin d.ok = 1'b1; d.src = SRC_GBR; end
            if (sel == 4'h2) begin d.ok = 1'b1; d.src = SRC_VBR; end
        end else if (ins[15:12] == 4'h4 && ins[3:0] == 4'h2) begin
            d.push = 1'b1;
            if (sel == 4'h0) begin d.ok = 1'b1; d.src = SRC_MACH; end
            if (sel == 4'h1) begin d.ok = 1'b1; d.src = SRC_MACL; end
            if (sel == 4'h2) begin d.ok = 1'b1; d.src = SRC_PR;   end
        end
        return d;
    endfunction

endpackage

// File: rtl/crs_decoder.sv
module crs_decoder
    import crs_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    always_comb dec = decode(instr);
endmodule

// File: rtl/crs_src_mux.sv
module crs_src_mux
    import crs_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  src_e            sel,
    input  logic [XLEN-1:0] sr_val,
    input  logic [XLEN-1:0] gbr_val,
    input  logic [XLEN-1:0] vbr_val,
    input  logic [XLEN-1:0] mach_val,
    input  logic [XLEN-1:0] macl_val,
    input  logic [XLEN-1:0] pr_val,
    output logic [XLEN-1:0] val
);
    always_comb begin
        case (sel)
            SRC_SR:   val = sr_val;
            SRC_GBR:  val = gbr_val;
            SRC_VBR:  val = vbr_val;
            SRC_MACH: val = mach_val;
            SRC_MACL: val = macl_val;
            SRC_PR:   val = pr_val;
            default:  val = '0;
        endcase
    end
endmodule

// File: rtl/crs_seq.sv
module crs_seq
    import crs_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CNT_W     = 8,
    parameter int PUSH_STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  dec_t              dec,
    input  logic [XLEN-1:0]   rn_val,
    input  logic [XLEN-1:0]   src_val,
    input  logic              mem_ready,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cyc_count,
    output logic              illegal
);
    localparam logic [XLEN-1:0]  STEP = XLEN'(PUSH_STEP);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    st_e              state;
    logic [CNT_W-1:0] cnt;
    logic [XLEN-1:0]  dec_addr;
    logic [CNT_W-1:0] cnt_next;

    assign dec_addr = rn_val - STEP;
    assign cnt_next = (cnt == '1) ? cnt : cnt + ONE;
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_data   <= '0;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            cyc_count <= '0;
            illegal   <= 1'b0;
        end else begin
            wb_en   <= 1'b0;
            done    <= 1'b0;
            illegal <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (instr_valid) begin
                        if (!dec.ok) begin
                            illegal <= 1'b1;
                        end else begin
                            wb_en  <= 1'b1;
                            wb_idx <= dec.rn;
                            if (dec.push) begin
                                wb_data   <= dec_addr;
                                mem_addr  <= dec_addr;
                                mem_wdata <= src_val;
                                cnt       <= ONE;
                                if (dec.src == SRC_SR) begin
                                    state <= ST_GAP;
                                end else begin
                                    state   <= ST_STORE;
                                    mem_req <= 1'b1;
                                end
                            end else begin
                                wb_data   <= src_val;
                                done      <= 1'b1;
                                cyc_count <= ONE;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    state   <= ST_STORE;
                    mem_req <= 1'b1;
                    cnt     <= cnt_next;
                end
                ST_STORE: begin
                    if (mem_ready) begin
                        mem_req   <= 1'b0;
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        cyc_count <= cnt;
                    end else begin
                        cnt <= cnt_next;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crs_store_unit.sv
module crs_store_unit
    import crs_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    output logic [RIDX_W-1:0]  gpr_raddr,
    input  logic [XLEN-1:0]    gpr_rdata,
    input  logic [XLEN-1:0]    sr_val,
    input  logic [XLEN-1:0]    gbr_val,
    input  logic [XLEN-1:0]    vbr_val,
    input  logic [XLEN-1:0]    mach_val,
    input  logic [XLEN-1:0]    macl_val,
    input  logic [XLEN-1:0]    pr_val,
    output logic               wb_en,
    output logic [RIDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]    wb_data,
    output logic               mem_req,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic               mem_ready,
    output logic               busy,
    output logic               done,
    output logic [CNT_W-1:0]   cyc_count,
    output logic               illegal
);
    dec_t            dec;
    logic [XLEN-1:0] src_val;

    assign gpr_raddr = dec.rn;

    crs_decoder u_dec (
        .instr (instr),
        .dec   (dec)
    );

    crs_src_mux #(.XLEN(XLEN)) u_mux (
        .sel      (dec.src),
        .sr_val   (sr_val),
        .gbr_val  (gbr_val),
        .vbr_val  (vbr_val),
        .mach_val (mach_val),
        .macl_val (macl_val),
        .pr_val   (pr_val),
        .val      (src_val)
    );

    crs_seq #(.XLEN(XLEN), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .dec         (dec),
        .rn_val      (gpr_rdata),
        .src_val     (src_val),
        .mem_ready   (mem_ready),
        .wb_en       (wb_en),
        .wb_idx      (wb_idx),
        .wb_data     (wb_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .done        (done),
        .cyc_count   (cyc_count),
        .illegal     (illegal)
    );
endmodule

// File: rtl/crs_store_unit_chk.sv
module crs_store_unit_chk #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wb_en,
    input logic             mem_req,
    input logic [XLEN-1:0]  mem_addr,
    input logic [XLEN-1:0]  mem_wdata,
    input logic             mem_ready,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] cyc_count,
    input logic             illegal
);
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

    assert_ptr_before_store_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> (wb_en || $past(wb_en)));

    assert_gap_then_req_R5: assert property (@(posedge clk) disable iff (rst)
        busy && !mem_req |=> mem_req);

    assert_handshake_ends_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready |=> !mem_req && done && !busy);

    assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> cyc_count != '0);

    assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wb_en && !done && !mem_req);

    assert_req_busy_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
endmodule

bind crs_store_unit crs_store_unit_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wb_en     (wb_en),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .busy      (busy),
    .done      (done),
    .cyc_count (cyc_count),
    .illegal   (illegal)
);

// File: tb/tb_crs_store_unit.sv
module tb_crs_store_unit;

    localparam logic [31:0] SR_V   = 32'h0000_00F1;
    localparam logic [31:0] GBR_V  = 32'h1111_2222;
    localparam logic [31:0] VBR_V  = 32'h3333_4444;
    localparam logic [31:0] MACH_V = 32'h5555_6666;
    localparam logic [31:0] MACL_V = 32'h7777_8888;
    localparam logic [31:0] PR_V   = 32'h9999_AAAA;

    typedef struct packed {
        logic [15:0] ins;
        logic [3:0]  stall;
        logic        legal;
        logic        push;
        logic [31:0] val;
        logic [7:0]  cnt;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{16'h0112, 4'd0, 1'b1, 1'b0, GBR_V,  8'd1},  // R1 GBR move
        '{16'h0222, 4'd0, 1'b1, 1'b0, VBR_V,  8'd1},  // R1 VBR move
        '{16'h030A, 4'd0, 1'b1, 1'b0, MACH_V, 8'd1},  // R2 MACH move
        '{16'h041A, 4'd0, 1'b1, 1'b0, MACL_V, 8'd1},  // R2 MACL move
        '{16'h072A, 4'd0, 1'b1, 1'b0, PR_V,   8'd1},  // R2 PR move
        '{16'h4803, 4'd0, 1'b1, 1'b1, SR_V,   8'd2},  // R5 SR push
        '{16'h4913, 4'd0, 1'b1, 1'b1, GBR_V,  8'd1},  // R3 R4
        '{16'h4A23, 4'd2, 1'b1, 1'b1, VBR_V,  8'd1},  // R4 R6 stalled
        '{16'h4B02, 4'd0, 1'b1, 1'b1, MACH_V, 8'd1},
        '{16'h4C12, 4'd0, 1'b1, 1'b1, MACL_V, 8'd1},
        '{16'h4D22, 4'd0, 1'b1, 1'b1, PR_V,   8'd1},
        '{16'h4503, 4'd3, 1'b1, 1'b1, SR_V,   8'd2},  // R3 wrap, R6 SR+stall
        '{16'h4612, 4'd0, 1'b1, 1'b1, MACL_V, 8'd1},  // R3 wrap from 0
        '{16'h0002, 4'd0, 1'b0, 1'b0, 32'h0,  8'd0},  // R7 bad selector
        '{16'h0332, 4'd0, 1'b0, 1'b0, 32'h0,  8'd0},  // R7
        '{16'h4333, 4'd0, 1'b0, 1'b0, 32'h0,  8'd0},  // R7
        '{16'h1112, 4'd0, 1'b0, 1'b0, 32'h0,  8'd0},  // R7 bad top nibble
        '{16'h4004, 4'd0, 1'b0, 1'b0, 32'h0,  8'd0},  // R7 bad low nibble
        '{16'h003A, 4'd0, 1'b0, 1'b0, 32'h0,  8'd0}   // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [3:0]  gpr_raddr;
    logic [31:0] gpr_rdata;
    logic        wb_en, mem_req, busy, done, illegal;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data, mem_addr, mem_wdata;
    logic        mem_ready = 1'b1;
    logic [7:0]  cyc_count;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] rv(input logic [3:0] n);
        if (n == 4'd5) return 32'h0000_0002;
        if (n == 4'd6) return 32'h0000_0000;
        return 32'h4000_0000 | (32'(n) << 8);
    endfunction

    assign gpr_rdata = rv(gpr_raddr);

    crs_store_unit dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
        .sr_val(SR_V), .gbr_val(GBR_V), .vbr_val(VBR_V),
        .mach_val(MACH_V), .macl_val(MACL_V), .pr_val(PR_V),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .busy(busy), .done(done),
        .cyc_count(cyc_count), .illegal(illegal)
    );

    task automatic chk(input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic exec(input vec_t v, input bit poke);
        logic [3:0]  n;
        logic [31:0] ea;
        string       tag;
        n   = v.ins[11:8];
        ea  = rv(n) - 32'd4;
        tag = v.push ? "R3" : ((v.ins[3:0] == 4'h2) ? "R1" : "R2");
        @(negedge clk);
        instr = v.ins;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        if (!v.legal) begin
            chk(illegal == 1'b1, "R7 illegal raised", 32'(illegal), 32'd1);
            chk(!wb_en && !mem_req && !done, "R7 no side effect",
                {29'd0, wb_en, mem_req, done}, 32'd0);
            return;
        end
        chk(wb_en == 1'b1, {tag, " wb_en"}, 32'(wb_en), 32'd1);
        chk(wb_idx == n, {tag, " wb_idx"}, 32'(wb_idx), 32'(n));
        chk(wb_data == (v.push ? ea : v.val), {tag, " wb_data"},
            wb_data, v.push ? ea : v.val);
        if (!v.push) begin
            chk(done && cyc_count == 8'd1, "R6 move count",
                {23'd0, done, cyc_count}, {23'd0, 1'b1, 8'd1});
            chk(!busy, "R8 move not busy", 32'(busy), 32'd0);
            return;
        end
        chk(busy == 1'b1, "R8 busy in push", 32'(busy), 32'd1);
        if (v.cnt == 8'd2) begin
            chk(mem_req == 1'b0, "R5 no request with SR write-back", 32'(mem_req), 32'd0);
            @(negedge clk);
        end
        chk(mem_req == 1'b1, "R4 request up", 32'(mem_req), 32'd1);
        chk(mem_addr == ea, "R4 store address", mem_addr, ea);
        chk(mem_wdata == v.val, "R4 store data", mem_wdata, v.val);
        for (int i = 0; i < int'(v.stall); i++) begin
            mem_ready = 1'b0;
            if (poke) begin
                instr = 16'h0112;
                instr_valid = 1'b1;
            end
            @(negedge clk);
            chk(mem_req && mem_addr == ea && mem_wdata == v.val, "R4 held while not ready",
                mem_addr, ea);
        end
        mem_ready   = 1'b1;
        instr_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R6 done after store", 32'(done), 32'd1);
        chk(cyc_count == v.cnt + 8'(v.stall), "R6 cycle count",
            32'(cyc_count), 32'(v.cnt + 8'(v.stall)));
        chk(!mem_req && !busy, "R8 released", {30'd0, mem_req, busy}, 32'd0);
        if (poke) begin
            chk(!wb_en, "R8 ignored move absent", 32'(wb_en), 32'd0);
            @(negedge clk);
            chk(!wb_en && !done, "R8 ignored move never completes",
                {30'd0, wb_en, done}, 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!wb_en && !mem_req && !busy && !done && !illegal, "R9 state in reset",
            {27'd0, wb_en, mem_req, busy, done, illegal}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!wb_en && !mem_req && !busy && !done && !illegal, "R9 state after reset",
            {27'd0, wb_en, mem_req, busy, done, illegal}, 32'd0);

        for (int k = 0; k < NV; k++) exec(VEC[k], 1'b0);

        // R8: a move presented during a stalled push must be dropped
        exec('{16'h4913, 4'd3, 1'b1, 1'b1, GBR_V, 8'd1}, 1'b1);

        // Back-to-back: SR push right after an illegal word
        exec(VEC[13], 1'b0);
        exec(VEC[5], 1'b0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule